// File: doc/BRIEF.md
# Ethernet Controller Command and Interrupt Status Core

This block is the control heart of a classic byte-wide Ethernet controller. A single command byte, reachable at offset 0 from every register page, starts and stops the controller, requests a transmission, selects the remote-DMA operation and chooses which of four register pages sits behind the shared address window. An interrupt status byte collects events from the transmitter, the receiver, remote DMA and the tally counters. Software acknowledges an event by writing a one to its bit.

A mask byte gates the status bits onto one level interrupt line. The transmit request is edge-sensitive: only a fresh low-to-high write produces a start pulse toward the transmitter. The counter-overflow flag is held set for as long as the tally counters report that they sit at their limit, so it can only be acknowledged after those counters have been read down.

Top module: `nic_ctl_core`

## Requirements
- R1: After reset the command byte reads 0x21. Its layout is stop in bit 0, start in bit 1, transmit request in bit 2, remote-DMA code in bits 5:3 (reset code 3'b100) and page select in bits 7:6.
- R2: Status bit 7 (reset flag) is set after reset. It is also set whenever a command write moves the stop bit from 0 to 1.
- R3: Writing a one to a status bit clears it. Writing a zero leaves it unchanged.
- R4: Offset 0 is the command byte in every page. In page 0, offset 7 is interrupt status and offset 0xF is the mask. In page 1, offset 7 is an 8-bit current-page register. Every other page and offset reads 0, and writes to them are ignored. A write at offset 7 in page 1 does not touch status.
- R5: Writing transmit request = 1 while it reads 0 gives a one-cycle `tx_go` pulse, and the bit then reads 1 until a transmit-done or transmit-error event. Writing it 0, or writing 1 again while it is set, has no effect and gives no pulse.
- R6: Status bit 5 (counter overflow) is set and stays set while `tally_sat` is high. A write-one clear takes effect only once `tally_sat` is low.
- R7: Each event pulse sets its own status bit: bit 0 packet received, bit 1 packet sent, bit 2 receive error, bit 3 transmit error, bit 4 overwrite warning, bit 6 remote DMA complete.
- R8: `irq` is high exactly while some status bit and its mask bit are both 1. The mask resets to 0.
- R9: When an event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A command write with bit 0 set stops the controller and clears start. A write with bit 0 clear and bit 1 set starts it. `running` shows the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset within the selected page |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| ev_rx_ok | input | 1 | Packet received pulse |
| ev_tx_ok | input | 1 | Packet transmitted pulse |
| ev_rx_err | input | 1 | Receive error pulse |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_ovw | input | 1 | Receive ring overwrite warning pulse |
| ev_rdma_done | input | 1 | Remote DMA complete pulse |
| tally_sat | input | 1 | Level, high while any tally counter is at its limit |
| irq | output | 1 | Level interrupt |
| tx_go | output | 1 | One-cycle transmit start pulse |
| running | output | 1 | Start bit of the command byte |
| page_sel | output | 2 | Current register page |
| rdma_cmd | output | 3 | Current remote-DMA code |

## Verification
A corrupted status bit shows up on `irq` in the same cycle whenever its mask bit is set. It also shows up on the next status read, so each acknowledge is followed by a read-back. A wrong transmit-request state shows as a missing, doubled or spurious `tx_go` pulse within one cycle of the command write, and as a wrong bit 2 on the next command read. A broken page decode shows as status changing after a page-1 write, or as nonzero data from an unused page.

// File: rtl/nic_ctl_pkg.sv
// Package: shared layout of the command byte, status bit indices and
// register offsets for the controller core.
package nic_ctl_pkg;

    localparam int DATA_W = 8;
    localparam int ISR_W  = 8;

    // Command byte, field positions decoded by software.
    typedef struct packed {
        logic [1:0] page;
        logic [2:0] rdma;
        logic       txp;
        logic       sta;
        logic       stp;
    } cmd_t;

    localparam cmd_t CMD_RST = '{page: 2'd0, rdma: 3'b100, txp: 1'b0,
                                 sta: 1'b0, stp: 1'b1};

    // Status bit indices.
    localparam int IS_PRX = 0;
    localparam int IS_PTX = 1;
    localparam int IS_RXE = 2;
    localparam int IS_TXE = 3;
    localparam int IS_OVW = 4;
    localparam int IS_CNT = 5;
    localparam int IS_RDC = 6;
    localparam int IS_RST = 7;

    localparam logic [ISR_W-1:0] ISR_RST_VAL = ISR_W'(1) << IS_RST;

    // Register offsets.
    localparam int OFS_CMD  = 0;
    localparam int OFS_ISR  = 7;
    localparam int OFS_CURR = 7;
    localparam int OFS_IMR  = 15;

endpackage

// File: rtl/nic_cmd_reg.sv
// Module: command byte holder.
// Holds stop/start, the edge-triggered transmit request, remote-DMA code
// and page select. Assumes wr_en is a single-cycle strobe. Issues one
// tx_go pulse per low-to-high transmit-request write and reports the
// entry into the stopped state.
module nic_cmd_reg
    import nic_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_done,
    output cmd_t              cmd_q,
    output logic              tx_go,
    output logic              stop_enter
);

    // Stop entry: a write asking to stop while not yet stopped.
    assign stop_enter = wr_en && wdata[0] && !cmd_q.stp;

    // Update the command fields and generate the transmit start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_RST;
            tx_go <= 1'b0;
        end else begin
            tx_go <= 1'b0;
            if (tx_done) begin
                cmd_q.txp <= 1'b0;
            end
            if (wr_en) begin
                cmd_q.page <= wdata[7:6];
                cmd_q.rdma <= wdata[5:3];
                if (wdata[0]) begin
                    cmd_q.stp <= 1'b1;
                    cmd_q.sta <= 1'b0;
                end else if (wdata[1]) begin
                    cmd_q.stp <= 1'b0;
                    cmd_q.sta <= 1'b1;
                end
                if (wdata[2] && !cmd_q.txp) begin
                    cmd_q.txp <= 1'b1;
                    tx_go     <= 1'b1;
                end
            end
        end
    end

    // R5
    txgo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_q.txp) |-> tx_go);

    // R5
    txgo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |=> !tx_go);

    // R10
    stp_sta_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_q.stp && cmd_q.sta));

endmodule

// File: rtl/nic_isr_reg.sv
// Module: interrupt status byte.
// Each bit is set by its set line and cleared by a write-one. A set in
// the same cycle as a clear wins. Assumes level sets (such as a
// saturated counter) are held on the set line for as long as they last.
module nic_isr_reg #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] isr_q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit set/clear flop with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                isr_q[i] <= RST_VAL[i];
            end else if (set_vec[i]) begin
                isr_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                isr_q[i] <= 1'b0;
            end
        end

        // R9
        set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> isr_q[i]);

        // R3
        clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !isr_q[i]);

        // R3
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[i] && !set_vec[i]) |=> (isr_q[i] == $past(isr_q[i])));
    end

endmodule

// File: rtl/nic_reg_decode.sv
// Module: paged register decode.
// Turns offset, page and strobes into per-register write enables and
// muxes read data. Assumes the strobes last one cycle. Unused pages and
// offsets read zero and accept no writes.
module nic_reg_decode
    import nic_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        page,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic [DATA_W-1:0] isr_byte,
    input  logic [DATA_W-1:0] imr_byte,
    input  logic [DATA_W-1:0] curr_byte,
    output logic              wr_cmd,
    output logic              wr_isr,
    output logic              wr_imr,
    output logic              wr_curr,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(OFS_ISR);
    localparam logic [ADDR_W-1:0] A_CURR = ADDR_W'(OFS_CURR);
    localparam logic [ADDR_W-1:0] A_IMR  = ADDR_W'(OFS_IMR);

    logic hit_cmd, hit_isr, hit_imr, hit_curr;

    // Address and page hit detection.
    always_comb begin
        hit_cmd  = (addr == A_CMD);
        hit_isr  = (page == 2'd0) && (addr == A_ISR);
        hit_imr  = (page == 2'd0) && (addr == A_IMR);
        hit_curr = (page == 2'd1) && (addr == A_CURR);
    end

    assign wr_cmd  = wr && hit_cmd;
    assign wr_isr  = wr && hit_isr;
    assign wr_imr  = wr && hit_imr;
    assign wr_curr = wr && hit_curr;

    // Read data mux, zero when idle or unmapped.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (hit_cmd)       rdata = cmd_byte;
            else if (hit_isr)  rdata = isr_byte;
            else if (hit_imr)  rdata = imr_byte;
            else if (hit_curr) rdata = curr_byte;
        end
    end

endmodule

// File: rtl/nic_ctl_core.sv
// Module: controller command and interrupt status core (top).
// Joins the command byte, status byte, mask and current-page register
// behind a paged 8-bit register bus and drives the level interrupt.
// Assumes event inputs are synchronous one-cycle pulses and tally_sat is
// a synchronous level.
module nic_ctl_core
    import nic_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ev_rx_ok,
    input  logic              ev_tx_ok,
    input  logic              ev_rx_err,
    input  logic              ev_tx_err,
    input  logic              ev_ovw,
    input  logic              ev_rdma_done,
    input  logic              tally_sat,
    output logic              irq,
    output logic              tx_go,
    output logic              running,
    output logic [1:0]        page_sel,
    output logic [2:0]        rdma_cmd
);

    cmd_t              cmd_q;
    logic              stop_enter;
    logic              wr_cmd, wr_isr, wr_imr, wr_curr;
    logic [ISR_W-1:0]  isr_q, isr_set, isr_clr;
    logic [DATA_W-1:0] imr_q, curr_q;

    nic_cmd_reg u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_cmd),
        .wdata      (bus_wdata),
        .tx_done    (ev_tx_ok || ev_tx_err),
        .cmd_q      (cmd_q),
        .tx_go      (tx_go),
        .stop_enter (stop_enter)
    );

    // Collect the set sources per status bit.
    always_comb begin
        isr_set         = '0;
        isr_set[IS_PRX] = ev_rx_ok;
        isr_set[IS_PTX] = ev_tx_ok;
        isr_set[IS_RXE] = ev_rx_err;
        isr_set[IS_TXE] = ev_tx_err;
        isr_set[IS_OVW] = ev_ovw;
        isr_set[IS_CNT] = tally_sat;
        isr_set[IS_RDC] = ev_rdma_done;
        isr_set[IS_RST] = stop_enter;
    end

    assign isr_clr = wr_isr ? bus_wdata : '0;

    nic_isr_reg #(
        .W       (ISR_W),
        .RST_VAL (ISR_RST_VAL)
    ) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (isr_set),
        .clr_vec (isr_clr),
        .isr_q   (isr_q)
    );

    // Mask and current-page registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= '0;
            curr_q <= '0;
        end else begin
            if (wr_imr)  imr_q  <= bus_wdata;
            if (wr_curr) curr_q <= bus_wdata;
        end
    end

    nic_reg_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .page      (cmd_q.page),
        .cmd_byte  (cmd_q),
        .isr_byte  (isr_q),
        .imr_byte  (imr_q),
        .curr_byte (curr_q),
        .wr_cmd    (wr_cmd),
        .wr_isr    (wr_isr),
        .wr_imr    (wr_imr),
        .wr_curr   (wr_curr),
        .rdata     (bus_rdata)
    );

    assign irq      = |(isr_q & imr_q);
    assign running  = cmd_q.sta;
    assign page_sel = cmd_q.page;
    assign rdma_cmd = cmd_q.rdma;

    // R2
    rst_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |=> isr_q[IS_RST]);

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tally_sat |=> isr_q[IS_CNT]);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imr_q == '0) |-> !irq);

    // R4
    curr_page_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && cmd_q.page != 2'd1) |=> $stable(curr_q));

endmodule

// File: tb/nic_ctl_core_bench.sv
`timescale 1ns/1ps
module nic_ctl_core_bench;

    localparam int SEL_RD  = 0;
    localparam int SEL_IRQ = 1;
    localparam int SEL_TXG = 2;
    localparam int SEL_RUN = 3;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] ev = '0;
    logic       tally_sat = 1'b0;
    logic       irq, tx_go, running;
    logic [1:0] page_sel;
    logic [2:0] rdma_cmd;

    item_t q[$];
    int    n_run = 0, n_fail = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    nic_ctl_core u_nic_ctl_core (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx_ok(ev[0]), .ev_tx_ok(ev[1]), .ev_rx_err(ev[2]),
        .ev_tx_err(ev[3]), .ev_ovw(ev[4]), .ev_rdma_done(ev[5]),
        .tally_sat(tally_sat), .irq(irq), .tx_go(tx_go), .running(running),
        .page_sel(page_sel), .rdma_cmd(rdma_cmd)
    );

    // Monitor: pops one expected item per cycle and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sel)
                    SEL_RD:  act = bus_rdata;
                    SEL_IRQ: act = {7'd0, irq};
                    SEL_TXG: act = {7'd0, tx_go};
                    default: act = {7'd0, running};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver tasks: each starts and ends at a falling edge.
    task automatic chk(input int sel, input logic [3:0] a, input logic [7:0] e, input string tag);
        bus_rd   = (sel == SEL_RD);
        bus_addr = a;
        q.push_back('{sel: sel, exp: e, tag: tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        ev[idx] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int bitpos[6] = '{0, 1, 2, 3, 4, 6};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        chk(SEL_RD, 4'h0, 8'h21, "R1 reset command");
        chk(SEL_RD, 4'h7, 8'h80, "R2 reset flag after reset");
        chk(SEL_IRQ, 4'h0, 8'h00, "R8 irq low with mask zero");
        chk(SEL_RUN, 4'h0, 8'h00, "R10 not running after reset");

        wr(4'h7, 8'h00);
        chk(SEL_RD, 4'h7, 8'h80, "R3 zero write keeps bit");
        wr(4'h7, 8'h80);
        chk(SEL_RD, 4'h7, 8'h00, "R3 write one clears");

        wr(4'h0, 8'h22);
        chk(SEL_RD, 4'h0, 8'h22, "R10 start command");
        chk(SEL_RUN, 4'h0, 8'h01, "R10 running after start");
        chk(SEL_RD, 4'h7, 8'h00, "R2 no reset flag on start");
        wr(4'h0, 8'h21);
        chk(SEL_RD, 4'h7, 8'h80, "R2 reset flag on stop entry");
        chk(SEL_RUN, 4'h0, 8'h00, "R10 stopped");
        wr(4'h0, 8'h22);
        wr(4'h7, 8'hFF);

        for (int k = 0; k < 6; k++) begin
            pulse(k);
            chk(SEL_RD, 4'h7, 8'(1 << bitpos[k]), "R7 event bit position");
            wr(4'h7, 8'hFF);
        end

        wr(4'hF, 8'h01);
        chk(SEL_RD, 4'hF, 8'h01, "R8 mask readback");
        chk(SEL_IRQ, 4'h0, 8'h00, "R8 irq idle");
        pulse(0);
        chk(SEL_IRQ, 4'h0, 8'h01, "R8 irq on masked event");
        wr(4'hF, 8'h00);
        chk(SEL_IRQ, 4'h0, 8'h00, "R8 irq masked off");
        wr(4'hF, 8'h01);
        wr(4'h7, 8'h01);
        chk(SEL_IRQ, 4'h0, 8'h00, "R8 irq after acknowledge");
        wr(4'hF, 8'h00);

        wr(4'h0, 8'h26);
        chk(SEL_TXG, 4'h0, 8'h01, "R5 tx_go pulse");
        chk(SEL_TXG, 4'h0, 8'h00, "R5 tx_go one cycle");
        chk(SEL_RD, 4'h0, 8'h26, "R5 request bit set");
        wr(4'h0, 8'h22);
        chk(SEL_TXG, 4'h0, 8'h00, "R5 no pulse on low write");
        chk(SEL_RD, 4'h0, 8'h26, "R5 low write ignored");
        wr(4'h0, 8'h26);
        chk(SEL_TXG, 4'h0, 8'h00, "R5 no pulse on repeat");
        pulse(1);
        chk(SEL_RD, 4'h0, 8'h22, "R5 request cleared by done");
        chk(SEL_RD, 4'h7, 8'h02, "R7 transmit done bit");
        wr(4'h7, 8'hFF);

        wr(4'h0, 8'h62);
        chk(SEL_RD, 4'h0, 8'h62, "R4 command in page 1");
        wr(4'h7, 8'h5A);
        chk(SEL_RD, 4'h7, 8'h5A, "R4 current page register");
        pulse(0);
        wr(4'h7, 8'hFF);
        wr(4'h0, 8'h22);
        chk(SEL_RD, 4'h7, 8'h01, "R4 page 1 write leaves status");
        wr(4'h0, 8'hE2);
        chk(SEL_RD, 4'h7, 8'h00, "R4 page 3 reads zero");
        wr(4'h0, 8'h62);
        chk(SEL_RD, 4'h7, 8'hFF, "R4 current page written in page 1");
        wr(4'h0, 8'h22);
        wr(4'h7, 8'hFF);

        tally_sat = 1'b1;
        @(negedge clk);
        chk(SEL_RD, 4'h7, 8'h20, "R6 overflow bit set");
        wr(4'h7, 8'h20);
        chk(SEL_RD, 4'h7, 8'h20, "R6 clear blocked while saturated");
        tally_sat = 1'b0;
        wr(4'h7, 8'h20);
        chk(SEL_RD, 4'h7, 8'h00, "R6 clear after counters read");

        ev[4] = 1'b1;
        bus_wr = 1'b1; bus_addr = 4'h7; bus_wdata = 8'h10;
        @(negedge clk);
        ev = '0; bus_wr = 1'b0;
        chk(SEL_RD, 4'h7, 8'h10, "R9 set wins over clear");
        wr(4'hF, 8'h10);
        chk(SEL_IRQ, 4'h0, 8'h01, "R8 irq on other bit");

        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule